// File: doc/BRIEF.md
# Text RAM Write Decoder

This block sits between a CPU byte-write path and the memories behind a text display. Each strobed write carries a 20-bit address. The block decides which of three regions the address falls in, applies the protection rule for that region, and forwards a permitted write to either the text RAM port or the font RAM port. The decision is made in the cycle of the strobe. The write ports are registered and act on the following cycle.

Regions:
- **Character region** (0xA0000 to 0xA1FFF): always writable.
- **Attribute region** (0xA2000 to 0xA3FFF): accepts even bytes only. The upper words of its last 32 bytes are guarded by a memory-switch access enable.
- **Font window** (0xA4000 to 0xA4FFF): accepts odd bytes only, and only while a writable flag is set. A write here lands in one of sixteen font rows, counted from a programmable glyph base.

Every accepted text write marks a per-cell dirty flag and a global text-changed flag. The display side reads these back and clears them. Every strobe, accepted or not, presents a programmable wait-cycle charge on a separate output in the same cycle.

Top module: `text_wr_decoder`

## Requirements
- R1: A strobe with an address below 0xA0000, or at 0xA5000 or above, writes neither RAM port and changes no flag.
- R2: A strobe in 0xA0000 to 0xA1FFF raises `tram_we` on the next cycle, with `tram_addr` equal to address bits 13:0 and `tram_data` equal to the strobed byte.
- R3: A strobe to an odd address in 0xA2000 to 0xA3FFF is ignored.
- R4: An even strobe in 0xA2000 to 0xA3FFF is dropped when address bits 12:0 are at least 0x1FE0, address bit 1 is set and `sw_access_en` is low. Every other even strobe in that range is written as in R2.
- R5: An accepted text write sets the dirty flag at cell index address bits 12:1 and sets `text_changed`. Both are visible from the cycle after the strobe. `dirty_bit` shows the flag selected by `dirty_idx`, combinationally.
- R6: In 0xA4000 to 0xA4FFF, only an odd strobe with `cg_wen` high is written. It raises `font_we` on the next cycle, with `font_addr` equal to `glyph_base` plus address bits 4:1 (modulo the font address width) and `font_data` equal to the byte. Every other strobe in this range is ignored.
- R7: An accepted font write sets the sticky flag `cg_touched`.
- R8: `wait_out` equals `wait_cfg` in every cycle that `wr_en` is high, whatever the region or outcome. It is zero otherwise.
- R9: `disp_clr` clears all dirty flags, `text_changed` and `cg_touched` at the next clock edge. A write accepted in the same cycle still sets its own flags.
- R10: After reset, both write enables, all flags and `text_changed` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 20 | Write byte address |
| wr_data | input | 8 | Write byte |
| sw_access_en | input | 1 | Unlocks the guarded attribute tail |
| cg_wen | input | 1 | Font window writable |
| glyph_base | input | FONT_AW (12) | Font RAM row base of the current glyph |
| wait_cfg | input | WAIT_W (4) | Wait cycles charged per strobe |
| disp_clr | input | 1 | Clear of dirty and change flags from the display side |
| dirty_idx | input | CELL_AW (12) | Dirty flag read index |
| tram_we | output | 1 | Text RAM write enable |
| tram_addr | output | 14 | Text RAM byte address |
| tram_data | output | 8 | Text RAM write byte |
| font_we | output | 1 | Font RAM write enable |
| font_addr | output | FONT_AW (12) | Font RAM row address |
| font_data | output | 8 | Font RAM write byte |
| dirty_bit | output | 1 | Dirty flag at `dirty_idx` |
| text_changed | output | 1 | Some text cell was written since the last clear |
| cg_touched | output | 1 | A font write was accepted since the last clear |
| wait_out | output | WAIT_W (4) | Wait charge for the current strobe |

## Verification
`wait_out` is combinational. The bench checks it 1 ns after driving a strobe, before the next rising edge. The RAM write ports, the dirty flags, `text_changed` and `cg_touched` are all set one register stage after the strobe. The bench therefore updates its model at that rising edge and compares at the following falling edge. The bench points `dirty_idx` at the cell of the strobe it has just driven, so the flag read at that falling edge is the one the write may have set.

// File: rtl/twd_pkg.sv
// Shared region codes and fixed address boundaries of the decoder.
// Assumes a 20-bit byte address space with the window at 0xA0000.
package twd_pkg;
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_CHAR = 2'd1,
        RG_ATTR = 2'd2,
        RG_FONT = 2'd3
    } region_e;

    localparam logic [19:0] CHAR_LO  = 20'hA0000;
    localparam logic [19:0] ATTR_LO  = 20'hA2000;
    localparam logic [19:0] FONT_LO  = 20'hA4000;
    localparam logic [19:0] WIN_END  = 20'hA5000;
    localparam logic [12:0] TAIL_LO  = 13'h1FE0;
endpackage

// File: rtl/twd_classify.sv
// Combinational region decode and protection gating for one strobe.
// Assumes the caller qualifies the results with the write strobe.
module twd_classify
    import twd_pkg::*;
(
    input  logic [19:0] addr,
    input  logic        sw_en,
    input  logic        cg_wen,
    output region_e     region,
    output logic        text_ok,
    output logic        font_ok
);
    logic guarded_tail;

    // Region select from the fixed boundaries
    always_comb begin
        if (addr < CHAR_LO)      region = RG_NONE;
        else if (addr < ATTR_LO) region = RG_CHAR;
        else if (addr < FONT_LO) region = RG_ATTR;
        else if (addr < WIN_END) region = RG_FONT;
        else                     region = RG_NONE;
    end

    // Guarded upper words of the attribute tail
    assign guarded_tail = (addr[12:0] >= TAIL_LO) && addr[1];

    // Per-region acceptance rules
    always_comb begin
        text_ok = 1'b0;
        font_ok = 1'b0;
        unique case (region)
            RG_CHAR: text_ok = 1'b1;
            RG_ATTR: text_ok = !addr[0] && (!guarded_tail || sw_en);
            RG_FONT: font_ok = addr[0] && cg_wen;
            default: ;
        endcase
    end
endmodule

// File: rtl/twd_dirty_track.sv
// Per-cell dirty flags plus a global change flag.
// A set in the same cycle as a clear wins for its own cell.
module twd_dirty_track #(
    parameter int CELL_AW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [CELL_AW-1:0] set_idx,
    input  logic               clr,
    input  logic [CELL_AW-1:0] rd_idx,
    output logic               rd_bit,
    output logic               any_set
);
    localparam int CELLS = 1 << CELL_AW;

    logic [CELLS-1:0] flags;

    // Flag array: clear first, then the accepted write sets its cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (clr) flags <= '0;
            if (set_en) flags[set_idx] <= 1'b1;
        end
    end

    // Global change flag with the same clear/set ordering
    always_ff @(posedge clk) begin
        if (!rst_n)      any_set <= 1'b0;
        else if (set_en) any_set <= 1'b1;
        else if (clr)    any_set <= 1'b0;
    end

    assign rd_bit = flags[rd_idx];

    // R5: a set is reflected in the global flag and its cell next cycle
    a_r5_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> any_set && flags[$past(set_idx)]);

    // R9: a clear with no set leaves the global flag low
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_en) |=> !any_set);
endmodule

// File: rtl/twd_font_port.sv
// Registered font RAM write port and the sticky font-touched flag.
// Assumes fire is already gated by region, parity and writability.
module twd_font_port #(
    parameter int FONT_AW = 12,
    parameter int ROW_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [ROW_W-1:0]   row,
    input  logic [7:0]         data,
    input  logic [FONT_AW-1:0] base,
    input  logic               clr,
    output logic               we,
    output logic [FONT_AW-1:0] waddr,
    output logic [7:0]         wdata,
    output logic               touched
);
    // Write port register: row offset added to the glyph base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we    <= 1'b0;
            waddr <= '0;
            wdata <= '0;
        end else begin
            we <= fire;
            if (fire) begin
                waddr <= base + FONT_AW'(row);
                wdata <= data;
            end
        end
    end

    // Sticky touched flag; a write beats a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n)    touched <= 1'b0;
        else if (fire) touched <= 1'b1;
        else if (clr)  touched <= 1'b0;
    end

    // R7: every font write is accompanied by the touched flag
    a_r7_touched: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> touched);
endmodule

// File: rtl/text_wr_decoder.sv
// Top of the text RAM write decoder: classifies each strobe, drives the
// text or font write port one cycle later, tracks dirty cells and
// presents the wait charge combinationally with the strobe.
// Assumes at most one byte strobe per cycle.
module text_wr_decoder
    import twd_pkg::*;
#(
    parameter int CELL_AW = 12,
    parameter int FONT_AW = 12,
    parameter int WAIT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [19:0]        wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               sw_access_en,
    input  logic               cg_wen,
    input  logic [FONT_AW-1:0] glyph_base,
    input  logic [WAIT_W-1:0]  wait_cfg,
    input  logic               disp_clr,
    input  logic [CELL_AW-1:0] dirty_idx,
    output logic               tram_we,
    output logic [13:0]        tram_addr,
    output logic [7:0]         tram_data,
    output logic               font_we,
    output logic [FONT_AW-1:0] font_addr,
    output logic [7:0]         font_data,
    output logic               dirty_bit,
    output logic               text_changed,
    output logic               cg_touched,
    output logic [WAIT_W-1:0]  wait_out
);
    localparam int ROW_W = 4;

    region_e rgn;
    logic    text_ok;
    logic    font_ok;
    logic    text_fire;
    logic    font_fire;

    twd_classify u_classify (
        .addr    (wr_addr),
        .sw_en   (sw_access_en),
        .cg_wen  (cg_wen),
        .region  (rgn),
        .text_ok (text_ok),
        .font_ok (font_ok)
    );

    assign text_fire = wr_en && text_ok;
    assign font_fire = wr_en && font_ok;

    // Text RAM write port register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tram_we   <= 1'b0;
            tram_addr <= '0;
            tram_data <= '0;
        end else begin
            tram_we <= text_fire;
            if (text_fire) begin
                tram_addr <= wr_addr[13:0];
                tram_data <= wr_data;
            end
        end
    end

    twd_dirty_track #(.CELL_AW(CELL_AW)) u_dirty (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (text_fire),
        .set_idx (wr_addr[CELL_AW:1]),
        .clr     (disp_clr),
        .rd_idx  (dirty_idx),
        .rd_bit  (dirty_bit),
        .any_set (text_changed)
    );

    twd_font_port #(.FONT_AW(FONT_AW), .ROW_W(ROW_W)) u_font (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (font_fire),
        .row     (wr_addr[ROW_W:1]),
        .data    (wr_data),
        .base    (glyph_base),
        .clr     (disp_clr),
        .we      (font_we),
        .waddr   (font_addr),
        .wdata   (font_data),
        .touched (cg_touched)
    );

    // Wait charge for every strobe, accepted or not
    assign wait_out = wr_en ? wait_cfg : '0;

    // R2/R3: text writes only come from in-window, non-odd-attribute strobes
    a_r3_no_odd_attr: assert property (@(posedge clk) disable iff (!rst_n)
        tram_we |-> ($past(wr_addr) >= CHAR_LO) && ($past(wr_addr) < FONT_LO)
                    && !($past(wr_addr) >= ATTR_LO && $past(wr_addr[0])));

    // R6: font writes only from odd strobes while writable
    a_r6_font_gate: assert property (@(posedge clk) disable iff (!rst_n)
        font_we |-> $past(wr_addr[0]) && $past(cg_wen) && $past(wr_en));

    // R1: the two write ports are never active together
    a_r1_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tram_we, font_we}));

    // R5: a text write is always covered by the change flag
    a_r5_changed: assert property (@(posedge clk) disable iff (!rst_n)
        tram_we |-> text_changed);
endmodule

// File: tb/test_text_wr_decoder.sv
module test_text_wr_decoder;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        sw_access_en = 1'b0;
    logic        cg_wen = 1'b0;
    logic [11:0] glyph_base = '0;
    logic [3:0]  wait_cfg = '0;
    logic        disp_clr = 1'b0;
    logic [11:0] dirty_idx = '0;
    logic        tram_we, font_we, dirty_bit, text_changed, cg_touched;
    logic [13:0] tram_addr;
    logic [7:0]  tram_data, font_data;
    logic [11:0] font_addr;
    logic [3:0]  wait_out;

    int errors = 0;
    int checks = 0;

    logic [4095:0] m_dirty = '0;
    logic          m_changed = 1'b0;
    logic          m_touched = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    text_wr_decoder i_text_wr_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sw_access_en(sw_access_en), .cg_wen(cg_wen),
        .glyph_base(glyph_base), .wait_cfg(wait_cfg), .disp_clr(disp_clr),
        .dirty_idx(dirty_idx), .tram_we(tram_we), .tram_addr(tram_addr),
        .tram_data(tram_data), .font_we(font_we), .font_addr(font_addr),
        .font_data(font_data), .dirty_bit(dirty_bit),
        .text_changed(text_changed), .cg_touched(cg_touched),
        .wait_out(wait_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected outcome: 0 ignored, 1 text write, 2 font write
    function automatic int outcome(input logic [19:0] a, input logic sw, input logic cg);
        if (a >= 20'hA0000 && a <= 20'hA1FFF) return 1;
        if (a >= 20'hA2000 && a <= 20'hA3FFF) begin
            if (a[0]) return 0;
            if (a[12:0] >= 13'h1FE0 && a[1] && !sw) return 0;
            return 1;
        end
        if (a >= 20'hA4000 && a <= 20'hA4FFF) return (a[0] && cg) ? 2 : 0;
        return 0;
    endfunction

    // One strobe cycle: drive at falling edge, check wait, then registered results
    task automatic step(input logic [19:0] a, input logic [7:0] d, input logic we,
                        input logic sw, input logic cg, input logic clr,
                        input logic [11:0] gb, input logic [3:0] wc, input string tag);
        int o;
        logic [11:0] fexp;
        wr_en = we; wr_addr = a; wr_data = d; sw_access_en = sw; cg_wen = cg;
        disp_clr = clr; glyph_base = gb; wait_cfg = wc; dirty_idx = a[12:1];
        #1;
        chk({"R8 wait ", tag}, 32'(wait_out), we ? 32'(wc) : 32'd0);
        o = we ? outcome(a, sw, cg) : 0;
        fexp = gb + 12'(a[4:1]);
        @(posedge clk);
        if (clr) begin m_dirty = '0; m_changed = 1'b0; m_touched = 1'b0; end
        if (o == 1) begin m_dirty[a[12:1]] = 1'b1; m_changed = 1'b1; end
        if (o == 2) m_touched = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; disp_clr = 1'b0;
        chk({"R1/R2/R3/R4 tram_we ", tag}, 32'(tram_we), 32'(o == 1));
        chk({"R1/R6 font_we ", tag}, 32'(font_we), 32'(o == 2));
        if (o == 1) begin
            chk({"R2 tram_addr ", tag}, 32'(tram_addr), 32'(a[13:0]));
            chk({"R2 tram_data ", tag}, 32'(tram_data), 32'(d));
        end
        if (o == 2) begin
            chk({"R6 font_addr ", tag}, 32'(font_addr), 32'(fexp));
            chk({"R6 font_data ", tag}, 32'(font_data), 32'(d));
        end
        chk({"R5/R9 dirty_bit ", tag}, 32'(dirty_bit), 32'(m_dirty[a[12:1]]));
        chk({"R5/R9 text_changed ", tag}, 32'(text_changed), 32'(m_changed));
        chk({"R7/R9 cg_touched ", tag}, 32'(cg_touched), 32'(m_touched));
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 tram_we", 32'(tram_we), 0);
        chk("R10 font_we", 32'(font_we), 0);
        chk("R10 text_changed", 32'(text_changed), 0);
        chk("R10 cg_touched", 32'(cg_touched), 0);
        chk("R10 dirty_bit", 32'(dirty_bit), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        step(20'h9FFFF, 8'h11, 1, 0, 1, 0, 12'h100, 4'd3, "R1 below window");
        step(20'hA5000, 8'h12, 1, 1, 1, 0, 12'h100, 4'd5, "R1 above window");
        step(20'hA0000, 8'h21, 1, 0, 0, 0, 12'h100, 4'd2, "R2 first");
        step(20'hA1FFF, 8'h22, 1, 0, 0, 0, 12'h100, 4'd2, "R2 last odd");
        step(20'hA1FE2, 8'h23, 1, 0, 0, 0, 12'h100, 4'd2, "R2 tail unguarded");
        step(20'hA2001, 8'h31, 1, 1, 0, 0, 12'h100, 4'd7, "R3 odd attr");
        step(20'hA3FE2, 8'h41, 1, 0, 0, 0, 12'h100, 4'd1, "R4 guarded drop");
        step(20'hA3FFE, 8'h42, 1, 0, 0, 0, 12'h100, 4'd1, "R4 guarded top drop");
        step(20'hA3FE2, 8'h43, 1, 1, 0, 0, 12'h100, 4'd1, "R4 guarded unlocked");
        step(20'hA3FE4, 8'h44, 1, 0, 0, 0, 12'h100, 4'd1, "R4 tail bit1 clear");
        step(20'hA3FDE, 8'h45, 1, 0, 0, 0, 12'h100, 4'd1, "R4 below tail");
        step(20'hA4003, 8'h51, 1, 0, 0, 0, 12'h100, 4'd4, "R6 font not writable");
        step(20'hA4002, 8'h52, 1, 0, 1, 0, 12'h100, 4'd4, "R6 font even");
        step(20'hA401F, 8'h53, 1, 0, 1, 0, 12'hFFA, 4'd4, "R6 R7 font wrap");
        step(20'hA0000, 8'h00, 0, 0, 0, 1, 12'h000, 4'd9, "R9 clear idle");
        step(20'hA0100, 8'h61, 1, 0, 0, 1, 12'h000, 4'd6, "R9 clear with write");
        step(20'hA4005, 8'h62, 1, 0, 1, 1, 12'h020, 4'd6, "R9 clear with font");
        step(20'hA0100, 8'h63, 0, 0, 0, 0, 12'h020, 4'd6, "R8 idle");

        // Constrained random mix
        for (int i = 0; i < 2000; i++) begin
            logic [19:0] a;
            if ($urandom_range(0, 3) == 0) a = 20'hA3FE0 + 20'($urandom_range(0, 31));
            else a = 20'h9F000 + 20'($urandom_range(0, 20'h7000));
            step(a, 8'($urandom), ($urandom_range(0, 7) != 0),
                 1'($urandom), 1'($urandom), ($urandom_range(0, 15) == 0),
                 12'($urandom), 4'($urandom), "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule